// File: doc/BRIEF.md
# At-Speed Scan Clock Controller

This block picks and gates the clock that each scan flip-flop domain sees during at-speed scan test. Each domain has one fast clock from the on-chip PLL. There is also one slow tester clock and a vector of per-domain pulse-select bits, which a separate clock-control shift chain holds steady during capture.

In functional operation every domain output is its own PLL clock. In test operation with the PLL skipped, every output runs from the tester clock. In test operation with the PLL in use, the outputs follow the tester clock while shifting. When shift enable drops, the slow path closes. A trigger is then taken on the next tester-clock rising edge and carried into each fast domain through a two-flop synchronizer. Each domain then opens its gate for a fixed window of fast cycles and lets through only the cycles whose select bit is set. With two slots, selecting only the first slot gives launch-off-shift capture. Selecting both slots gives launch-off-capture. After the window the domain stays quiet until shift enable rises again, and the trigger re-arms from that point.

Both sources pass through a latch-and-AND clock gate that is transparent while its clock is low, so a source switch never cuts a pulse short. The pins are plain control and clock lines. There is no streaming data path, so there is no valid/ready handshake.

Top module: `occ_clk_mux`

## Requirements
- R1: While `rst_in` is 1, no fast capture pulse reaches any `dom_clk` output, even when a capture sequence is applied.
- R2: With `dft_mode` = 0, each `dom_clk[d]` toggles exactly as `pll_clk[d]` does.
- R3: With `dft_mode` = 1 and `pll_skip` = 1, every `dom_clk[d]` shows one rising edge per `tester_clk` rising edge, whatever `shift_en` and `pulse_sel` are.
- R4: With `dft_mode` = 1, `pll_skip` = 0 and `shift_en` = 1, every `dom_clk[d]` shows one rising edge per `tester_clk` rising edge.
- R5: With `dft_mode` = 1 and `pll_skip` = 0, after `shift_en` falls, domain d issues one fast pulse for each set bit among `pulse_sel[2*d]` (slot 0, first fast cycle of the window) and `pulse_sel[2*d+1]` (slot 1, the next fast cycle).
- R6: Once a domain's pulse window ends, its output stays quiet for as long as `shift_en` stays 0, so no pulse is re-issued within one capture.
- R7: Between the fall of `shift_en` and the trigger edge on `tester_clk`, no output edge occurs. Every high phase of an output during capture lasts at least half a period of its source clock.
- R8: After `shift_en` returns to 1, a later fall of `shift_en` starts a new capture window that follows the new `pulse_sel` value.
- R9: Each domain's pulse count depends only on its own two select bits, even though the domains run on fast clocks of different periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_in | input | 1 | Asynchronous controller reset, active high |
| dft_mode | input | 1 | 1 = test operation, 0 = outputs are the PLL clocks |
| pll_skip | input | 1 | In test operation, 1 = all outputs run from the tester clock |
| shift_en | input | 1 | Scan shift enable; its fall starts a capture window |
| pulse_sel | input | NUM_DOM*SLOTS | Per-domain slot enables; bit SLOTS*d+k is slot k of domain d |
| pll_clk | input | NUM_DOM | Fast PLL clock per domain |
| tester_clk | input | 1 | Slow tester clock |
| dom_clk | output | NUM_DOM | Scan clock delivered to each domain |

## Verification
The hardest condition to reach is the handover, where the slow path must be shut and the fast path not yet open. The window is only a fraction of a tester cycle, and the two fast domains run at periods unrelated to the tester clock and to each other. The stimulus drops `shift_en` during the low phase of `tester_clk`. It counts every output edge up to just past the next tester rising edge, and it measures the width of each output high phase across the whole capture. Holding `shift_en` low well beyond the window, then running a second capture with a different select pattern, shows that pulses are not re-issued and that the trigger re-arms.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_DONE = 2'd2
  } pg_state_e;
endpackage

// File: rtl/occ_clk_gate.sv
module occ_clk_gate (
  input  logic clk_in,
  input  logic en,
  output logic clk_gated
);
  logic en_held;

  // transparent while the clock is low, so the enable only changes in the low phase
  always_latch begin
    if (!clk_in) en_held = en;
  end

  assign clk_gated = clk_in & en_held;
endmodule

// File: rtl/occ_trigger.sv
module occ_trigger (
  input  logic tester_clk,
  input  logic rst_in,
  input  logic dft_mode,
  input  logic pll_skip,
  input  logic shift_en,
  output logic trig
);
  always_ff @(posedge tester_clk or posedge rst_in) begin
    if (rst_in) trig <= 1'b0;
    else        trig <= dft_mode & ~pll_skip & ~shift_en;
  end
endmodule

// File: rtl/occ_pulse_gen.sv
module occ_pulse_gen
  import occ_pkg::*;
#(
  parameter int SLOTS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic             trig,
  input  logic [SLOTS-1:0] slot_en,
  output logic             fire,
  output logic             armed
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  pg_state_e              state;
  logic [SW-1:0]          slot;
  logic [SW-1:0]          nxt_slot;

  assign armed    = sync_q[SYNC_STAGES-1];
  assign nxt_slot = slot + SW'(1);

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) begin
      sync_q <= '0;
      state  <= PG_IDLE;
      slot   <= '0;
      fire   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig};
      case (state)
        PG_IDLE: begin
          if (armed) begin
            state <= PG_RUN;
            slot  <= '0;
            fire  <= slot_en[0];
          end
        end
        PG_RUN: begin
          if (slot == LAST) begin
            state <= PG_DONE;
            fire  <= 1'b0;
          end else begin
            slot <= nxt_slot;
            fire <= slot_en[nxt_slot];
          end
        end
        PG_DONE: begin
          if (!armed) state <= PG_IDLE;
        end
        default: begin
          state <= PG_IDLE;
          fire  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/occ_clk_mux.sv
module occ_clk_mux #(
  parameter int NUM_DOM     = 2,
  parameter int SLOTS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     rst_in,
  input  logic                     dft_mode,
  input  logic                     pll_skip,
  input  logic                     shift_en,
  input  logic [NUM_DOM*SLOTS-1:0] pulse_sel,
  input  logic [NUM_DOM-1:0]       pll_clk,
  input  logic                     tester_clk,
  output logic [NUM_DOM-1:0]       dom_clk
);
  logic               trig;
  logic               slow_gated;
  logic [NUM_DOM-1:0] fast_fire;
  logic [NUM_DOM-1:0] fast_armed;
  logic [NUM_DOM-1:0] fast_gated;

  occ_trigger trig_i (
    .tester_clk(tester_clk),
    .rst_in    (rst_in),
    .dft_mode  (dft_mode),
    .pll_skip  (pll_skip),
    .shift_en  (shift_en),
    .trig      (trig)
  );

  occ_clk_gate slow_gate_i (
    .clk_in   (tester_clk),
    .en       (shift_en | pll_skip),
    .clk_gated(slow_gated)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    occ_pulse_gen #(
      .SLOTS      (SLOTS),
      .SYNC_STAGES(SYNC_STAGES)
    ) pgen_i (
      .clk    (pll_clk[d]),
      .rst_in (rst_in),
      .trig   (trig),
      .slot_en(pulse_sel[d*SLOTS +: SLOTS]),
      .fire   (fast_fire[d]),
      .armed  (fast_armed[d])
    );

    occ_clk_gate fast_gate_i (
      .clk_in   (pll_clk[d]),
      .en       (fast_fire[d]),
      .clk_gated(fast_gated[d])
    );

    assign dom_clk[d] = dft_mode ? (slow_gated | fast_gated[d]) : pll_clk[d];
  end
endmodule

// File: rtl/occ_clk_mux_chk.sv
module occ_clk_mux_chk #(
  parameter int NUM_DOM = 2,
  parameter int SLOTS   = 2
) (
  input logic                     rst_in,
  input logic [NUM_DOM-1:0]       pll_clk,
  input logic [NUM_DOM*SLOTS-1:0] pulse_sel,
  input logic [NUM_DOM-1:0]       fire,
  input logic [NUM_DOM-1:0]       armed
);
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chk
    logic [7:0] fired_cnt;

    always_ff @(posedge pll_clk[g] or posedge rst_in) begin
      if (rst_in)             fired_cnt <= '0;
      else if (!armed[g])     fired_cnt <= '0;
      else if (fire[g] && fired_cnt != 8'hFF) fired_cnt <= fired_cnt + 8'd1;
    end

    // R6
    fire_outside_window_chk: assert property (@(posedge pll_clk[g]) disable iff (rst_in)
      fire[g] |-> armed[g]);

    // R5
    fire_slot_enabled_chk: assert property (@(posedge pll_clk[g]) disable iff (rst_in)
      fire[g] |-> (|pulse_sel[g*SLOTS +: SLOTS]));

    // R6
    fire_budget_chk: assert property (@(posedge pll_clk[g]) disable iff (rst_in)
      fired_cnt <= 8'(SLOTS));

    // R7
    sync_latency_chk: assert property (@(posedge pll_clk[g]) disable iff (rst_in)
      $rose(armed[g]) |-> !fire[g]);
  end
endmodule

bind occ_clk_mux occ_clk_mux_chk #(
  .NUM_DOM(NUM_DOM),
  .SLOTS  (SLOTS)
) chk_i (
  .rst_in   (rst_in),
  .pll_clk  (pll_clk),
  .pulse_sel(pulse_sel),
  .fire     (fast_fire),
  .armed    (fast_armed)
);

// File: tb/occ_clk_mux_tb_top.sv
`timescale 1ns/100ps
module occ_clk_mux_tb_top;
  logic       rst_in;
  logic       dft_mode;
  logic       pll_skip;
  logic       shift_en;
  logic [3:0] pulse_sel;
  logic [1:0] pll_clk;
  logic       tester_clk;
  logic [1:0] dom_clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int out_cnt0 = 0, out_cnt1 = 0, pll_cnt0 = 0, pll_cnt1 = 0, slow_cnt = 0;
  int glitch0 = 0, glitch1 = 0;
  bit watch = 0;
  realtime rise0 = 0, rise1 = 0;

  occ_clk_mux dut_i (
    .rst_in    (rst_in),
    .dft_mode  (dft_mode),
    .pll_skip  (pll_skip),
    .shift_en  (shift_en),
    .pulse_sel (pulse_sel),
    .pll_clk   (pll_clk),
    .tester_clk(tester_clk),
    .dom_clk   (dom_clk)
  );

  // 250 MHz main fast clock, a second unrelated fast clock, 25 MHz tester clock
  initial pll_clk[0] = 1'b0;
  always #2 pll_clk[0] = ~pll_clk[0];
  initial pll_clk[1] = 1'b0;
  always #3 pll_clk[1] = ~pll_clk[1];
  initial tester_clk = 1'b0;
  always #20 tester_clk = ~tester_clk;

  always @(posedge dom_clk[0]) begin out_cnt0++; rise0 = $realtime; end
  always @(posedge dom_clk[1]) begin out_cnt1++; rise1 = $realtime; end
  always @(negedge dom_clk[0]) if (watch && ($realtime - rise0) < 1.9) glitch0++;
  always @(negedge dom_clk[1]) if (watch && ($realtime - rise1) < 2.9) glitch1++;
  always @(posedge pll_clk[0]) pll_cnt0++;
  always @(posedge pll_clk[1]) pll_cnt1++;
  always @(posedge tester_clk) slow_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic align();
    @(negedge tester_clk);
    #1.5;
  endtask

  function automatic int pop2(input logic [1:0] v);
    return int'(v[0]) + int'(v[1]);
  endfunction

  // R1: capture sequence under reset gives no pulses
  task automatic t_reset();
    int a0, a1;
    dft_mode = 1; pll_skip = 0; pulse_sel = 4'hF; shift_en = 1;
    repeat (2) align();
    a0 = out_cnt0; a1 = out_cnt1;
    shift_en = 0;
    #300;
    check(out_cnt0 == a0, "R1", "dom0 edges in reset", out_cnt0 - a0, 0);
    check(out_cnt1 == a1, "R1", "dom1 edges in reset", out_cnt1 - a1, 0);
    align();
    shift_en = 1;
    align();
    rst_in = 0;
  endtask

  // R2
  task automatic t_functional();
    int a0, a1, p0, p1;
    dft_mode = 0;
    align();
    a0 = out_cnt0; a1 = out_cnt1; p0 = pll_cnt0; p1 = pll_cnt1;
    #200;
    check(out_cnt0 - a0 == pll_cnt0 - p0, "R2", "dom0 functional edges", out_cnt0 - a0, pll_cnt0 - p0);
    check(out_cnt1 - a1 == pll_cnt1 - p1, "R2", "dom1 functional edges", out_cnt1 - a1, pll_cnt1 - p1);
    check(pll_cnt0 - p0 == 50, "R2", "dom0 reference edges", pll_cnt0 - p0, 50);
  endtask

  // R4
  task automatic t_shift();
    int a0, a1, s;
    dft_mode = 1; pll_skip = 0; shift_en = 1; pulse_sel = 4'hF;
    repeat (2) align();
    a0 = out_cnt0; a1 = out_cnt1; s = slow_cnt;
    #400;
    check(out_cnt0 - a0 == slow_cnt - s, "R4", "dom0 shift edges", out_cnt0 - a0, slow_cnt - s);
    check(out_cnt1 - a1 == 10, "R4", "dom1 shift edges", out_cnt1 - a1, 10);
  endtask

  // R3
  task automatic t_bypass();
    int a0, a1, s;
    dft_mode = 1; pll_skip = 1; pulse_sel = 4'hF; shift_en = 1;
    repeat (2) align();
    shift_en = 0;
    repeat (2) align();
    a0 = out_cnt0; a1 = out_cnt1; s = slow_cnt;
    #400;
    check(out_cnt0 - a0 == slow_cnt - s, "R3", "dom0 bypass edges", out_cnt0 - a0, slow_cnt - s);
    check(out_cnt1 - a1 == 10, "R3", "dom1 bypass edges", out_cnt1 - a1, 10);
    shift_en = 1;
    align();
    pll_skip = 0;
    align();
  endtask

  // R5 R6 R7 R8 R9
  task automatic t_capture(input logic [3:0] pat, input string req);
    int a0, a1, e0, e1;
    dft_mode = 1; pll_skip = 0; pulse_sel = pat; shift_en = 1;
    repeat (3) align();
    a0 = out_cnt0; a1 = out_cnt1;
    glitch0 = 0; glitch1 = 0;
    watch = 1;
    shift_en = 0;
    @(posedge tester_clk);
    #0.5;
    check(out_cnt0 == a0, "R7", "dom0 edges during handover", out_cnt0 - a0, 0);
    check(out_cnt1 == a1, "R7", "dom1 edges during handover", out_cnt1 - a1, 0);
    #300;
    e0 = pop2(pat[1:0]); e1 = pop2(pat[3:2]);
    check(out_cnt0 - a0 == e0, req, "dom0 capture pulses", out_cnt0 - a0, e0);
    check(out_cnt1 - a1 == e1, req, "dom1 capture pulses", out_cnt1 - a1, e1);
    #400;
    check(out_cnt0 - a0 == e0, "R6", "dom0 pulses after window", out_cnt0 - a0, e0);
    check(out_cnt1 - a1 == e1, "R6", "dom1 pulses after window", out_cnt1 - a1, e1);
    check(glitch0 == 0, "R7", "dom0 short high phases", glitch0, 0);
    check(glitch1 == 0, "R7", "dom1 short high phases", glitch1, 0);
    watch = 0;
    align();
    shift_en = 1;
    repeat (2) align();
  endtask

  initial begin
    rst_in = 1; dft_mode = 1; pll_skip = 0; shift_en = 1; pulse_sel = 4'h0;
    #1;
    check(dom_clk == 2'b00, "R1", "outputs at start", int'(dom_clk), 0);
    t_reset();
    t_functional();
    t_shift();
    t_bypass();
    t_capture(4'b1111, "R5");
    t_capture(4'b0101, "R8");
    t_capture(4'b1001, "R9");
    t_capture(4'b0010, "R9");
    t_capture(4'b0000, "R5");
    t_shift();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule